// File: doc/BRIEF.md
# Cache Region Maintenance Sequencer

This block turns a single register write into a cache maintenance pass over a whole physical address range. Software sets an exclusive end address, an upper-address byte and, on the data side, a control word. It then writes the start address, and that write launches the pass. The sequencer rounds the start down to a line boundary and emits one request per cache line on a valid/ready port, in ascending order. Each request carries the line address and a 2-bit operation code. The pass ends after the request for the last line below the end address has been accepted.

There are two register channels, one for data and one for instruction. The instruction channel can only invalidate. Both channels feed a single sequencer, so only one pass runs at any time. A busy status is shown on a pin and in both channels' status words. While a pass runs, start writes from either channel are dropped. If both channels write their start register in the same idle cycle, the data channel launches and the instruction launch is dropped.

The cache side follows the usual stream rules. `req_valid` stays high while a pass has lines left. `req_addr`, `req_op` and `req_icache` hold steady until the cycle in which `req_ready` is also high. The next line is presented in the cycle after that. `req_ready` may stay low for any number of cycles.

Top module: `cache_rgn_seq`

## Requirements
- R1: A data start write (channel address 2) while idle produces requests for every line from the start rounded down to a multiple of LINE_BYTES up to the exclusive end, in ascending line order, one request per line, each address line-aligned.
- R2: The end bound is exclusive. If the end address is not line-aligned, the line containing it is still included, because earlier addresses of the range fall in it. An aligned end line is excluded.
- R3: The data control word (channel address 0) sets the opcode. Bit 0 = 1 gives invalidate, 2'b10. Bit 0 = 0 with bit 1 = 0 gives flush, 2'b01. Bit 0 = 0 with bit 1 = 1 gives flush-and-invalidate, 2'b11.
- R4: `busy` rises in the cycle after a launching write. It falls in the cycle after the last request is accepted. Bit 8 of read address 0 on both channels mirrors it.
- R5: Bits [7:0] of the upper-address register (channel address 3) form address bits 39:32 of both the start and the end of that channel's range.
- R6: Instruction-channel passes use the instruction channel's own end (1), start (2) and upper (3) registers. Every request of such a pass has opcode 2'b10 and `req_icache` = 1. Data passes have `req_icache` = 0.
- R7: If the end is at or below the rounded-down start, no request is issued and `busy` stays 0.
- R8: A start write on either channel during a pass is ignored. The running pass continues unchanged, and the start register reads back its earlier value.
- R9: When both channels write their start register in the same idle cycle, only the data range is processed.
- R10: While `req_valid` is high and `req_ready` is low, the request fields are held stable.
- R11: After reset, `busy` and `req_valid` are 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| d_we | input | 1 | Data channel register write strobe |
| d_addr | input | 2 | Data channel register select: 0 control, 1 end, 2 start, 3 upper |
| d_wdata | input | 32 | Data channel write data |
| d_rdata | output | 32 | Data channel read data (combinational) |
| i_we | input | 1 | Instruction channel register write strobe |
| i_addr | input | 2 | Instruction channel register select: 0 status, 1 end, 2 start, 3 upper |
| i_wdata | input | 32 | Instruction channel write data |
| i_rdata | output | 32 | Instruction channel read data (combinational) |
| busy | output | 1 | A region pass is in progress |
| req_valid | output | 1 | Line request valid |
| req_ready | input | 1 | Cache side accepts the request |
| req_addr | output | 40 | Line-aligned physical address |
| req_op | output | 2 | 01 flush, 10 invalidate, 11 flush and invalidate |
| req_icache | output | 1 | Request targets the instruction cache |

## Verification
The bench uses the default parameters: 64-byte lines, a 40-bit address and a 32-bit register word. With these values the upper byte can move a range above 4 GiB, and a range can lie just below the 32-bit boundary. Ranges of a few lines keep partial first and last lines, aligned and unaligned ends, and empty ranges all within short runs. Three ready patterns are used: always ready, alternating, and long stalls. Together they exercise request holding and back-to-back acceptance under the same reference model.

// File: rtl/cache_rgn_pkg.sv
package cache_rgn_pkg;

  typedef enum logic [1:0] {
    LOP_NONE      = 2'b00,
    LOP_FLUSH     = 2'b01,
    LOP_INVAL     = 2'b10,
    LOP_FLUSH_INV = 2'b11
  } line_op_e;

  localparam logic [1:0] RSEL_CTRL  = 2'd0;
  localparam logic [1:0] RSEL_END   = 2'd1;
  localparam logic [1:0] RSEL_START = 2'd2;
  localparam logic [1:0] RSEL_UPPER = 2'd3;

  localparam int BUSY_BIT = 8;

endpackage

// File: rtl/cache_rgn_chan.sv
module cache_rgn_chan
  import cache_rgn_pkg::*;
#(
  parameter int LO_W     = 32,
  parameter int ADDR_W   = 40,
  parameter bit HAS_CTRL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [LO_W-1:0]   wdata,
  input  logic              busy,
  output logic [LO_W-1:0]   rdata,
  output logic              start_wr,
  output logic [ADDR_W-1:0] rng_start,
  output logic [ADDR_W-1:0] rng_end,
  output line_op_e          rng_op
);
  localparam int HI_W = ADDR_W - LO_W;

  logic [LO_W-1:0] end_q;
  logic [LO_W-1:0] start_q;
  logic [HI_W-1:0] hi_q;
  logic [1:0]      ctrl_q;

  assign start_wr  = we && (addr == RSEL_START);
  assign rng_start = {hi_q, wdata};
  assign rng_end   = {hi_q, end_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q   <= '0;
      start_q <= '0;
      hi_q    <= '0;
    end else if (we) begin
      case (addr)
        RSEL_END:   end_q <= wdata;
        RSEL_START: if (!busy) start_q <= wdata;
        RSEL_UPPER: hi_q  <= wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  generate
    if (HAS_CTRL) begin : g_ctrl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            ctrl_q <= '0;
        else if (we && (addr == RSEL_CTRL))    ctrl_q <= wdata[1:0];
      end
      always_comb begin
        if (ctrl_q[0])      rng_op = LOP_INVAL;
        else if (ctrl_q[1]) rng_op = LOP_FLUSH_INV;
        else                rng_op = LOP_FLUSH;
      end
    end else begin : g_fixed
      assign ctrl_q = '0;
      assign rng_op = LOP_INVAL;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    case (addr)
      RSEL_CTRL: begin
        rdata[1:0]      = ctrl_q;
        rdata[BUSY_BIT] = busy;
      end
      RSEL_END:   rdata = end_q;
      RSEL_START: rdata = start_q;
      default:    rdata[HI_W-1:0] = hi_q;
    endcase
  end

endmodule

// File: rtl/cache_rgn_arb.sv
module cache_rgn_arb
  import cache_rgn_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic              d_start_wr,
  input  logic [ADDR_W-1:0] d_start,
  input  logic [ADDR_W-1:0] d_end,
  input  line_op_e          d_op,
  input  logic              i_start_wr,
  input  logic [ADDR_W-1:0] i_start,
  input  logic [ADDR_W-1:0] i_end,
  input  logic              busy,
  output logic              go,
  output logic [ADDR_W-1:0] go_start,
  output logic [ADDR_W-1:0] go_end,
  output line_op_e          go_op,
  output logic              go_ic
);
  logic pick_d;
  logic pick_i;

  assign pick_d = d_start_wr && !busy;
  assign pick_i = i_start_wr && !busy && !d_start_wr;
  assign go     = pick_d || pick_i;
  assign go_ic  = pick_i;

  always_comb begin
    if (pick_i) begin
      go_start = i_start;
      go_end   = i_end;
      go_op    = LOP_INVAL;
    end else begin
      go_start = d_start;
      go_end   = d_end;
      go_op    = d_op;
    end
  end

endmodule

// File: rtl/cache_rgn_walker.sv
module cache_rgn_walker
  import cache_rgn_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_start,
  input  logic [ADDR_W-1:0] go_end,
  input  line_op_e          go_op,
  input  logic              go_ic,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output line_op_e          req_op,
  output logic              req_icache
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam logic [ADDR_W:0] STEP = (ADDR_W+1)'(LINE_BYTES);

  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] end_q;
  line_op_e          op_q;
  logic              ic_q;
  logic              busy_q;
  logic [ADDR_W-1:0] aligned;
  logic              empty;
  logic [ADDR_W:0]   next_w;
  logic              last;
  logic              fire;

  assign aligned = {go_start[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign empty   = (go_end <= aligned);
  assign next_w  = {1'b0, cur_q} + STEP;
  assign last    = (next_w >= {1'b0, end_q});
  assign fire    = busy_q && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      end_q  <= '0;
      op_q   <= LOP_NONE;
      ic_q   <= 1'b0;
    end else if (go && !busy_q) begin
      if (!empty) begin
        busy_q <= 1'b1;
        cur_q  <= aligned;
        end_q  <= go_end;
        op_q   <= go_op;
        ic_q   <= go_ic;
      end
    end else if (fire) begin
      cur_q <= next_w[ADDR_W-1:0];
      if (last) busy_q <= 1'b0;
    end
  end

  assign busy       = busy_q;
  assign req_valid  = busy_q;
  assign req_addr   = cur_q;
  assign req_op     = op_q;
  assign req_icache = ic_q;

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                   && $stable(req_op) && $stable(req_icache)));

  a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[OFF_W-1:0] == '0));

  a_r2_below_end: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr < end_q));

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !last) |=>
      (req_valid && ({1'b0, req_addr} == {1'b0, $past(req_addr)} + STEP)));

  a_r8_launch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy_q);

  a_r7_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (go && empty) |=> !busy_q);

endmodule

// File: rtl/cache_rgn_seq.sv
module cache_rgn_seq
  import cache_rgn_pkg::*;
#(
  parameter int LO_W       = 32,
  parameter int ADDR_W     = 40,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_we,
  input  logic [1:0]        d_addr,
  input  logic [LO_W-1:0]   d_wdata,
  output logic [LO_W-1:0]   d_rdata,
  input  logic              i_we,
  input  logic [1:0]        i_addr,
  input  logic [LO_W-1:0]   i_wdata,
  output logic [LO_W-1:0]   i_rdata,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        req_op,
  output logic              req_icache
);
  logic              d_start_wr, i_start_wr;
  logic [ADDR_W-1:0] d_start, d_end, i_start, i_end;
  line_op_e          d_op, i_op, go_op, w_op;
  logic              go, go_ic;
  logic [ADDR_W-1:0] go_start, go_end;

  cache_rgn_chan #(.LO_W(LO_W), .ADDR_W(ADDR_W), .HAS_CTRL(1'b1)) u_dchan (
    .clk(clk), .rst_n(rst_n), .we(d_we), .addr(d_addr), .wdata(d_wdata),
    .busy(busy), .rdata(d_rdata), .start_wr(d_start_wr),
    .rng_start(d_start), .rng_end(d_end), .rng_op(d_op)
  );

  cache_rgn_chan #(.LO_W(LO_W), .ADDR_W(ADDR_W), .HAS_CTRL(1'b0)) u_ichan (
    .clk(clk), .rst_n(rst_n), .we(i_we), .addr(i_addr), .wdata(i_wdata),
    .busy(busy), .rdata(i_rdata), .start_wr(i_start_wr),
    .rng_start(i_start), .rng_end(i_end), .rng_op(i_op)
  );

  cache_rgn_arb #(.ADDR_W(ADDR_W)) u_arb (
    .d_start_wr(d_start_wr), .d_start(d_start), .d_end(d_end), .d_op(d_op),
    .i_start_wr(i_start_wr), .i_start(i_start), .i_end(i_end),
    .busy(busy), .go(go), .go_start(go_start), .go_end(go_end),
    .go_op(go_op), .go_ic(go_ic)
  );

  cache_rgn_walker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_walk (
    .clk(clk), .rst_n(rst_n), .go(go), .go_start(go_start), .go_end(go_end),
    .go_op(go_op), .go_ic(go_ic), .busy(busy), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_op(w_op),
    .req_icache(req_icache)
  );

  assign req_op = w_op;

  a_r6_icache_inval: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_icache) |-> (req_op == 2'b10));

  a_r6_ichan_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    i_op == LOP_INVAL);

  a_r9_data_first: assert property (@(posedge clk) disable iff (!rst_n)
    (d_start_wr && i_start_wr && !busy && (d_end > go_start)) |=> (busy && !req_icache));

endmodule

// File: tb/cache_rgn_seq_tb.sv
module cache_rgn_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        d_we = 1'b0, i_we = 1'b0;
  logic [1:0]  d_addr = 2'd0, i_addr = 2'd0;
  logic [31:0] d_wdata = '0, i_wdata = '0;
  logic [31:0] d_rdata, i_rdata;
  logic        busy, req_valid, req_icache;
  logic        req_ready = 1'b0;
  logic [39:0] req_addr;
  logic [1:0]  req_op;

  cache_rgn_seq u_dut (
    .clk(clk), .rst_n(rst_n), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
    .d_rdata(d_rdata), .i_we(i_we), .i_addr(i_addr), .i_wdata(i_wdata),
    .i_rdata(i_rdata), .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_op(req_op), .req_icache(req_icache)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0, rdy_mode = 0;
  string tag = "R11";

  longint unsigned qa[$];
  int qo[$];
  int qi[$];
  logic [31:0] m_dctrl = 0, m_dend = 0, m_dstart = 0, m_dhi = 0;
  logic [31:0] m_iend = 0, m_istart = 0, m_ihi = 0;

  task automatic fin();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void push_range(longint unsigned s, longint unsigned e, int op, int ic);
    longint unsigned a = s & ~longint'(63);
    while (a < e) begin
      qa.push_back(a); qo.push_back(op); qi.push_back(ic);
      a += 64;
    end
  endfunction

  function automatic int dop(logic [31:0] c);
    if (c[0]) return 2;
    if (c[1]) return 3;
    return 1;
  endfunction

  // one clock: inputs applied now are taken at the next edge
  task automatic tick();
    bit r_dwe = d_we, r_iwe = i_we, r_rdy = req_ready;
    logic [1:0] r_da = d_addr, r_ia = i_addr;
    logic [31:0] r_dw = d_wdata, r_iw = i_wdata;
    bit pre_busy;
    bit dgo;
    @(posedge clk);
    #1;
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      fin();
    end
    pre_busy = (qa.size() != 0);
    if (pre_busy && r_rdy) begin
      void'(qa.pop_front()); void'(qo.pop_front()); void'(qi.pop_front());
    end
    dgo = r_dwe && r_da == 2 && !pre_busy;
    if (dgo)
      push_range({m_dhi[7:0], r_dw}, {m_dhi[7:0], m_dend}, dop(m_dctrl), 0);
    else if (r_iwe && r_ia == 2 && !pre_busy)
      push_range({m_ihi[7:0], r_iw}, {m_ihi[7:0], m_iend}, 2, 1);
    if (r_dwe) case (r_da)
      0: m_dctrl = r_dw & 32'h3;
      1: m_dend = r_dw;
      2: if (!pre_busy) m_dstart = r_dw;
      default: m_dhi = r_dw & 32'hff;
    endcase
    if (r_iwe) case (r_ia)
      1: m_iend = r_iw;
      2: if (!pre_busy) m_istart = r_iw;
      3: m_ihi = r_iw & 32'hff;
      default: ;
    endcase
    // per-cycle comparison with the reference queue
    check(busy == (qa.size() != 0), {tag, " R4 busy"}, busy, qa.size() != 0);
    check(req_valid == (qa.size() != 0), {tag, " R1 valid"}, req_valid, qa.size() != 0);
    if (req_valid && qa.size() != 0) begin
      check(req_addr == qa[0], {tag, " R1 addr"}, req_addr, qa[0]);
      check(req_op == qo[0][1:0], {tag, " R3 op"}, req_op, qo[0]);
      check(req_icache == qi[0][0], {tag, " R6 icache"}, req_icache, qi[0]);
    end
    case (rdy_mode)
      0: req_ready = 1'b1;
      1: req_ready = cycles[0];
      default: req_ready = (cycles % 5 == 0);
    endcase
  endtask

  task automatic wd(input logic [1:0] a, input logic [31:0] v);
    d_we = 1; d_addr = a; d_wdata = v; tick(); d_we = 0;
  endtask

  task automatic wi(input logic [1:0] a, input logic [31:0] v);
    i_we = 1; i_addr = a; i_wdata = v; tick(); i_we = 0;
  endtask

  task automatic drain();
    for (int k = 0; k < 400 && qa.size() != 0; k++) tick();
    tick(); tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    for (int a = 0; a < 4; a++) begin
      d_addr = 2'(a); i_addr = 2'(a); #0.5;
      check(d_rdata == 0, "R11 d reg", d_rdata, 0);
      check(i_rdata == 0, "R11 i reg", i_rdata, 0);
    end
    check(busy == 0 && req_valid == 0, "R11 idle", {busy, req_valid}, 0);
    rst_n = 1;
    tick();

    tag = "R1"; rdy_mode = 0;
    wd(1, 32'h1000_0100); wd(2, 32'h1000_0010); drain();

    tag = "R2"; rdy_mode = 1;
    wd(0, 1); wd(1, 32'h281); wd(2, 32'h200); drain();
    wd(1, 32'h280); wd(2, 32'h200); drain();

    tag = "R5"; rdy_mode = 2;
    wd(0, 2); wd(3, 32'h5a); wd(1, 32'hffff_fff0); wd(2, 32'hffff_ff80);
    d_addr = 0; #0.5;
    check(d_rdata[8] == 1, "R4 d status busy", d_rdata[8], 1);
    i_addr = 0; #0.5;
    check(i_rdata[8] == 1, "R4 i status busy", i_rdata[8], 1);
    drain();
    d_addr = 0; #0.5;
    check(d_rdata[8] == 0, "R4 d status idle", d_rdata[8], 0);
    wd(3, 0);

    tag = "R7"; rdy_mode = 0;
    wd(0, 0); wd(1, 32'h1000); wd(2, 32'h1010); tick(); tick();
    check(busy == 0, "R7 empty no busy", busy, 0);
    wd(2, 32'h1000); tick();
    check(busy == 0, "R7 equal no busy", busy, 0);

    tag = "R6"; rdy_mode = 1;
    wi(3, 1); wi(1, 32'h3080); wi(2, 32'h3000); drain();

    tag = "R8"; rdy_mode = 2;
    wd(1, 32'h4400); wd(2, 32'h4000);
    wd(2, 32'h9000); wi(2, 32'h7000); wd(1, 32'h4800);
    d_addr = 2; #0.5;
    check(d_rdata == 32'h4000, "R8 start kept", d_rdata, 32'h4000);
    drain();

    tag = "R9"; rdy_mode = 0;
    wi(3, 0); wi(1, 32'h6100); wd(1, 32'h5080);
    d_we = 1; d_addr = 2; d_wdata = 32'h5000;
    i_we = 1; i_addr = 2; i_wdata = 32'h6000;
    tick(); d_we = 0; i_we = 0;
    check(req_icache == 0, "R9 data wins", req_icache, 0);
    drain();

    tag = "R10"; rdy_mode = 2;
    wd(0, 1); wd(1, 32'h8200); wd(2, 32'h8000); drain();

    fin();
  end
endmodule